// File: doc/BRIEF.md
# Gated General-Purpose Input Port

This block samples up to 32 external input pins and presents their levels in one read-only 32-bit register. Each pin is admitted through its own bit of an enable mask. A separate local source loads the mask by pulsing a load strobe with the new value. While a pin is enabled, its held bit follows the synchronised pin level. While it is disabled, the held bit keeps its value. Loading a mask that drops a pin clears that pin's held bit at the same clock edge.

A one-cycle interrupt pulse marks each clock edge at which at least one enabled held bit goes from 0 to 1. Several pins rising together produce a single pulse. Software reads the register over a simple request/response bus. The bus runs a four-state machine: `ST_IDLE`, `ST_READ`, `ST_WRITE` and `ST_FAULT`.

- A request whose access is aligned and full-word moves the machine to `ST_READ` if it is a read, or to `ST_WRITE` if it is a write.
- Any other request moves it to `ST_FAULT`.
- With no request, the machine moves to `ST_IDLE`.

Every non-idle state lasts exactly one cycle and produces the response.

Top module: `gated_input_port`

## Requirements
- R1: A read request at word offset 0 (byte address 0), with all four byte enables set, is answered in the next cycle. The answer has `rsp_valid`=1, `rsp_err`=0 and `rsp_data` equal to the held value after that clock edge. Bit i of the data is pin i, so byte 0 carries pins 7..0.
- R2: A request that does not have all byte enables set (`bus_be`≠4'hF), or whose `bus_addr` is non-zero, is answered in the next cycle with `rsp_err`=1 and `rsp_data`=0.
- R3: `NUM_PINS` may be 0 to 32. Held bits at or above `NUM_PINS` always read 0.
- R4: A full-word write to offset 0 is answered with `rsp_valid`=1, `rsp_err`=0 and `rsp_data`=0. It leaves the held value unchanged.
- R5: Each pin passes through a two-flop synchroniser. A pin change set up before clock edge k is in the held value, and in the interrupt, after edge k+2.
- R6: An enabled pin's held bit follows the synchronised level. A disabled pin's held bit keeps its value.
- R7: `irq_pulse` is high for one cycle after any edge at which an enabled held bit goes from 0 to 1. Falling levels give no pulse. Simultaneous rises give a single pulse.
- R8: In the cycle where `en_load`=1, the mask takes `en_value` and the held value is ANDed with `en_value`, effective at that same edge. No pin capture takes place in that cycle.
- R9: After reset, the mask, the held value, `irq_pulse` and `rsp_valid` are all 0. Pins therefore have no effect until a mask is loaded.
- R10: Enabling a pin that is already high captures it on the cycle after the load and raises one interrupt pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 32 | Raw asynchronous pins; bits at or above NUM_PINS are ignored |
| en_load | input | 1 | Strobe that loads the enable mask |
| en_value | input | 32 | New enable mask, 1 = pin enabled |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_be | input | 4 | Byte enables, all four required |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Access rejected (partial or bad address) |
| rsp_data | output | 32 | Read data |
| irq_pulse | output | 1 | One-cycle rising-edge interrupt |

## Verification
The hardest situation to reach is a mask load that lands on the very edge where a read is sampled. In that case the response must already show the newly disabled bits as zero. The stimulus raises `en_load` and `bus_req` in the same cycle, so the response shows the held value as it stands after that one edge. A second hard case is a pin that is already high when its enable bit is set. The vectors keep such pins steady across a load, so the only possible source of a pulse is the load itself.

// File: rtl/gip_pkg.sv
package gip_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned BE_W   = WORD_W / 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_FAULT
    } bus_state_t;
endpackage

// File: rtl/gip_sync.sv
module gip_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= async_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gip_capture.sv
module gip_capture
    import gip_pkg::*;
#(
    parameter int unsigned NUM_PINS = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] pin_sync,
    input  logic              en_load,
    input  logic [WORD_W-1:0] en_value,
    output logic [WORD_W-1:0] held,
    output logic              irq
);
    localparam logic [63:0]       FULL_MASK = (64'd1 << NUM_PINS) - 64'd1;
    localparam logic [WORD_W-1:0] PIN_MASK  = FULL_MASK[WORD_W-1:0];

    logic [WORD_W-1:0] mask_q;
    logic [WORD_W-1:0] rising;

    assign rising = pin_sync & mask_q & ~held;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            held   <= '0;
            irq    <= 1'b0;
        end else if (en_load) begin
            mask_q <= en_value & PIN_MASK;
            held   <= held & en_value;
            irq    <= 1'b0;
        end else begin
            held   <= (held & ~mask_q) | (pin_sync & mask_q);
            irq    <= |rising;
        end
    end

    // R6: disabled bits keep their value when no load happens
    assert_hold_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en_load |=> ((held ^ $past(held)) & ~$past(mask_q)) == '0);

    // R8: a load clears every bit not present in the new mask
    assert_load_masks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        en_load |=> (held & ~$past(en_value)) == '0);

    // R7: a pulse always coincides with a bit that just went high
    assert_irq_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (held & ~$past(held)) != '0);

    // R3: bits above the pin count never become set
    assert_upper_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (held & ~PIN_MASK) == '0);
endmodule

// File: rtl/gip_bus.sv
module gip_bus
    import gip_pkg::*;
#(
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned NUM_PINS = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BE_W-1:0]   be,
    input  logic [WORD_W-1:0] held,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [WORD_W-1:0] rsp_data
);
    localparam logic [63:0]       FULL_MASK = (64'd1 << NUM_PINS) - 64'd1;
    localparam logic [WORD_W-1:0] PIN_MASK  = FULL_MASK[WORD_W-1:0];

    bus_state_t state_q, state_d;
    logic       bad_access;

    assign bad_access = (be != {BE_W{1'b1}}) || (addr != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = ST_IDLE;
        if (req) begin
            if (bad_access) state_d = ST_FAULT;
            else if (we)    state_d = ST_WRITE;
            else            state_d = ST_READ;
        end
    end

    always_comb begin
        rsp_valid = 1'b0;
        rsp_err   = 1'b0;
        rsp_data  = '0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_READ: begin
                rsp_valid = 1'b1;
                rsp_data  = held;
            end
            ST_WRITE: rsp_valid = 1'b1;
            ST_FAULT: begin
                rsp_valid = 1'b1;
                rsp_err   = 1'b1;
            end
            default:  ;
        endcase
    end

    assert_resp_next_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> rsp_valid);

    assert_bad_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && bad_access) |=> (rsp_err && rsp_data == '0));

    assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_data & ~PIN_MASK) == '0);

    assert_write_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && !bad_access) |=> (!rsp_err && rsp_data == '0));
endmodule

// File: rtl/gated_input_port.sv
module gated_input_port
    import gip_pkg::*;
#(
    parameter int unsigned NUM_PINS    = 24,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned ADDR_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       pin_in,
    input  logic              en_load,
    input  logic [31:0]       en_value,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_data,
    output logic              irq_pulse
);
    logic [WORD_W-1:0] pin_sync;
    logic [WORD_W-1:0] held;

    gip_sync #(.WIDTH(WORD_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gip_capture #(.NUM_PINS(NUM_PINS)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_sync (pin_sync),
        .en_load  (en_load),
        .en_value (en_value),
        .held     (held),
        .irq      (irq_pulse)
    );

    gip_bus #(.ADDR_W(ADDR_W), .NUM_PINS(NUM_PINS)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (bus_req),
        .we        (bus_we),
        .addr      (bus_addr),
        .be        (bus_be),
        .held      (held),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .rsp_data  (rsp_data)
    );
endmodule

// File: tb/tb_gated_input_port.sv
`timescale 1ns/1ps
module tb_gated_input_port;
    localparam int NV = 8;
    localparam logic [NV-1:0] V_LOAD = 8'b1110_1001; // bit v = load in vector v
    localparam logic [31:0] V_MASK [NV] = '{32'h0000_00FF, 32'h0, 32'h0, 32'h0000_FF0F,
                                            32'h0, 32'hFFFF_FFFF, 32'h0, 32'h0080_0001};
    localparam logic [31:0] V_PINS [NV] = '{32'h0000_0F0F, 32'h0000_0F00, 32'h0000_00F1, 32'h0000_00F1,
                                            32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0080_0001};
    localparam logic [31:0] V_HELD [NV] = '{32'h0000_000F, 32'h0, 32'h0000_00F1, 32'h0000_0001,
                                            32'h0000_FF0F, 32'h00FF_FFFF, 32'h0, 32'h0080_0001};
    localparam int V_PULSE [NV] = '{1, 0, 1, 0, 1, 1, 0, 1};

    logic clk = 1'b0, rst_n = 1'b0;
    logic [31:0] pin_in = '0, en_value = '0;
    logic en_load = 1'b0, bus_req = 1'b0, bus_we = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [3:0] bus_be = 4'hF;
    logic rsp_valid, rsp_err, irq_pulse;
    logic [31:0] rsp_data;
    int total = 0, bad = 0, pulses = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gated_input_port dut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .en_load(en_load), .en_value(en_value),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_be(bus_be),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data), .irq_pulse(irq_pulse)
    );

    always @(negedge clk) if (irq_pulse) pulses++;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [3:0] addr, input logic [3:0] be);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = addr; bus_be = be;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_be = 4'hF;
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait_cycles(3);
        check("R9 irq in reset", {31'b0, irq_pulse}, 32'h0);
        check("R9 rsp_valid in reset", {31'b0, rsp_valid}, 32'h0);
        rst_n = 1'b1;
        pin_in = 32'hFFFF_FFFF;
        pulses = 0;
        wait_cycles(6);
        access(1'b0, 4'h0, 4'hF);
        check("R9 held zero with zero mask", rsp_data, 32'h0);
        check("R9 no pulse with zero mask", pulses, 0);
        pin_in = '0;
        wait_cycles(4);

        // R6 R7 R8 R10 vector table
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            pin_in = V_PINS[v];
            pulses = 0;
            if (V_LOAD[v]) begin
                en_load = 1'b1; en_value = V_MASK[v];
                @(negedge clk);
                en_load = 1'b0;
            end
            wait_cycles(6);
            access(1'b0, 4'h0, 4'hF);
            check($sformatf("R1 vector %0d valid", v), {31'b0, rsp_valid & ~rsp_err}, 32'h1);
            check($sformatf("R6/R3/R10 vector %0d held", v), rsp_data, V_HELD[v]);
            check($sformatf("R7/R10 vector %0d pulses", v), pulses, V_PULSE[v]);
        end

        // R4: write ignored, held stays 0x800001
        access(1'b1, 4'h0, 4'hF);
        check("R4 write response", {30'b0, rsp_valid, rsp_err}, 32'h2);
        check("R4 write data", rsp_data, 32'h0);
        access(1'b0, 4'h0, 4'hF);
        check("R4 held unchanged", rsp_data, 32'h0080_0001);

        // R2: partial and misaligned accesses
        access(1'b0, 4'h0, 4'h3);
        check("R2 partial read", {rsp_data[29:0], rsp_valid, rsp_err}, 32'h3);
        access(1'b0, 4'h4, 4'hF);
        check("R2 bad address", {rsp_data[29:0], rsp_valid, rsp_err}, 32'h3);
        access(1'b0, 4'h1, 4'hF);
        check("R2 unaligned", {rsp_data[29:0], rsp_valid, rsp_err}, 32'h3);

        // R8: load and read in the same cycle
        @(negedge clk);
        en_load = 1'b1; en_value = 32'h0000_0001;
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = '0; bus_be = 4'hF;
        @(negedge clk);
        en_load = 1'b0; bus_req = 1'b0;
        check("R8 same-edge clear", rsp_data, 32'h0000_0001);

        // R5: synchroniser latency, R7 single-cycle pulse
        pin_in = '0;
        wait_cycles(5);
        pulses = 0;
        pin_in = 32'h0000_0001;
        @(negedge clk);
        check("R5 edge1 no irq", {31'b0, irq_pulse}, 32'h0);
        @(negedge clk);
        check("R5 edge2 no irq", {31'b0, irq_pulse}, 32'h0);
        @(negedge clk);
        check("R5 edge3 irq", {31'b0, irq_pulse}, 32'h1);
        @(negedge clk);
        check("R7 pulse one cycle", {31'b0, irq_pulse}, 32'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule